// File: doc/BRIEF.md
# Local-to-PCI Window Address Translator

This block turns a local-bus address into a PCI bus address through a small set of programmable windows. Each window has two registers: a base register giving the local start address, the window size, a prefetchable flag and an enable bit, and a map register giving the upper PCI address bits and a cycle-type code. A simple register write port loads these registers.

Each lookup returns its result one clock later. The result carries a hit flag, the index of the winning window, the translated PCI address, the cycle type and the prefetchable flag. Windows may overlap. The lowest-numbered enabled window that covers the address wins. Software can use this to hide a window behind an enlarged lower window and retarget it, for example to configuration space. In that case the low two PCI address bits are either forced to zero or passed through, as the map register selects. The block does not generate bus cycles.

Top module: `lwin_xlate`

## Requirements
- R1: After reset all base and map registers are zero, so every window is disabled, and `rs_valid`, `rs_hit` and `rs_addr` are 0.
- R2: A lookup presented with `lk_valid` high produces its result in the next cycle with `rs_valid` high. `rs_valid` is low in the cycle after a cycle without `lk_valid`.
- R3: Base register bit 0 enables the window. A window whose bit 0 is 0 never matches.
- R4: Base bits 7:4 hold a size code c. The window spans 2^(20+c) bytes, and codes above 12 act as 12 (the whole 4 GB space). The window matches when the local address bits above the size equal base bits 31:20 in those positions.
- R5: On a hit, the PCI address bits above the window size come from map bits 15:4, which stand for PCI bits 31:20. The bits below the window size pass through from the local address.
- R6: When several enabled windows match, the one with the lowest index wins, and `rs_win` reports that index.
- R7: `rs_ctype` reports map bits 3:1 of the winning window (3'b011 is memory). `rs_pref` reports base bit 2 of the winning window.
- R8: When the cycle type is 3'b101 (configuration) and map bit 0 is 0, PCI address bits 1:0 are forced to 00. With map bit 0 set, or for any other cycle type, they pass through from the local address.
- R9: A lookup that matches no window gives `rs_hit`=0, `rs_addr`=0, `rs_win`=0, `rs_ctype`=0 and `rs_pref`=0.
- R10: A write with `cfg_sel`=0 loads the base register from `cfg_wdata`. A write with `cfg_sel`=1 loads the map register from `cfg_wdata[15:0]`. A write takes effect for lookups in later cycles, so a lookup in the same cycle sees the old value. A write to a window index of NWIN or above has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | WIN_W | Window index for the write |
| cfg_sel | input | 1 | 0 = base register, 1 = map register |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Local address to translate |
| rs_valid | output | 1 | Result valid, one cycle after the lookup |
| rs_hit | output | 1 | Some enabled window matched |
| rs_win | output | WIN_W | Index of the winning window |
| rs_addr | output | 32 | Translated PCI address |
| rs_ctype | output | 3 | Cycle type of the winning window |
| rs_pref | output | 1 | Winning window is prefetchable |

## Verification
Lookups are aimed at the first and last bytes of 1 MB, 16 MB, 256 MB and 512 MB windows and at the addresses just outside them. This separates a correct size decode from an off-by-one mask. Overlapping windows are probed at an address that both cover, which exposes priority inversion. A configuration window is probed with map bit 0 both clear and set, which shows whether the two low bits are forced or passed. Writes issued in the same cycle as a lookup, and writes to an index out of range, show when a register change becomes visible and that a write aimed outside the window set is ignored.

// File: rtl/lwin_pkg.sv
package lwin_pkg;
  localparam int AW      = 32;
  localparam int PAGE_W  = 20;
  localparam int HI_W    = AW - PAGE_W;
  localparam int SZW     = 4;
  localparam int CT_W    = 3;
  localparam int MAP_W   = 16;
  localparam int MAX_SZ  = HI_W;

  localparam logic [CT_W-1:0] CT_MEM = 3'b011;
  localparam logic [CT_W-1:0] CT_CFG = 3'b101;

  // Mask of the 1 MB page bits that lie above the window size.
  function automatic logic [HI_W-1:0] hi_keep(input logic [SZW-1:0] code);
    int unsigned c;
    logic [HI_W-1:0] low;
    c   = (int'(code) > MAX_SZ) ? MAX_SZ : int'(code);
    low = (HI_W'(1) << c) - HI_W'(1);
    return ~low;
  endfunction

  function automatic logic win_hit(input logic [AW-1:0] addr,
                                   input logic [AW-1:0] base);
    logic [HI_W-1:0] keep;
    keep = hi_keep(base[7:4]);
    return base[0] && (((addr[AW-1:PAGE_W] ^ base[AW-1:PAGE_W]) & keep) == '0);
  endfunction

  function automatic logic [AW-1:0] win_xlate(input logic [AW-1:0]    addr,
                                              input logic [AW-1:0]    base,
                                              input logic [MAP_W-1:0] map);
    logic [HI_W-1:0] keep;
    logic [HI_W-1:0] hi;
    logic [1:0]      lo2;
    keep = hi_keep(base[7:4]);
    hi   = (map[MAP_W-1:4] & keep) | (addr[AW-1:PAGE_W] & ~keep);
    lo2  = (map[3:1] == CT_CFG && !map[0]) ? 2'b00 : addr[1:0];
    return {hi, addr[PAGE_W-1:2], lo2};
  endfunction
endpackage

// File: rtl/lwin_regs.sv
module lwin_regs
  import lwin_pkg::*;
#(
  parameter int NWIN  = 3,
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [WIN_W-1:0]            win,
  input  logic                        sel,
  input  logic [AW-1:0]               wdata,
  output logic [NWIN-1:0][AW-1:0]     base_q,
  output logic [NWIN-1:0][MAP_W-1:0]  map_q
);
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic hit_w;
    assign hit_w = we && (int'(win) == w);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[w] <= '0;
        map_q[w]  <= '0;
      end else if (hit_w) begin
        if (!sel) base_q[w] <= wdata;
        else      map_q[w]  <= wdata[MAP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lwin_match.sv
module lwin_match
  import lwin_pkg::*;
(
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    base,
  input  logic [MAP_W-1:0] map,
  output logic             hit,
  output logic [AW-1:0]    xaddr
);
  assign hit   = win_hit(addr, base);
  assign xaddr = win_xlate(addr, base, map);
endmodule

// File: rtl/lwin_prio.sv
module lwin_prio #(
  parameter int NWIN  = 3,
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [NWIN-1:0]  req,
  output logic [NWIN-1:0]  grant_oh,
  output logic [WIN_W-1:0] grant_idx,
  output logic             any
);
  always_comb begin
    grant_oh  = '0;
    grant_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant_oh  = '0;
        grant_oh[i] = 1'b1;
        grant_idx = WIN_W'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/lwin_xlate.sv
module lwin_xlate
  import lwin_pkg::*;
#(
  parameter int NWIN  = 3,
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [WIN_W-1:0] cfg_win,
  input  logic             cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_addr,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic [WIN_W-1:0] rs_win,
  output logic [AW-1:0]    rs_addr,
  output logic [CT_W-1:0]  rs_ctype,
  output logic             rs_pref
);
  logic [NWIN-1:0][AW-1:0]    base_q;
  logic [NWIN-1:0][MAP_W-1:0] map_q;
  logic [NWIN-1:0][AW-1:0]    xaddr_vec;
  logic [NWIN-1:0]            match_vec;
  logic [NWIN-1:0]            win_oh;
  logic [WIN_W-1:0]           win_idx;
  logic                       any_hit;

  lwin_regs #(.NWIN(NWIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .win(cfg_win), .sel(cfg_sel),
    .wdata(cfg_wdata), .base_q(base_q), .map_q(map_q)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    lwin_match u_match (
      .addr(lk_addr), .base(base_q[w]), .map(map_q[w]),
      .hit(match_vec[w]), .xaddr(xaddr_vec[w])
    );
  end

  lwin_prio #(.NWIN(NWIN)) u_prio (
    .req(match_vec), .grant_oh(win_oh), .grant_idx(win_idx), .any(any_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_win   <= '0;
      rs_addr  <= '0;
      rs_ctype <= '0;
      rs_pref  <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid && any_hit) begin
        rs_hit   <= 1'b1;
        rs_win   <= win_idx;
        rs_addr  <= xaddr_vec[win_idx];
        rs_ctype <= map_q[win_idx][3:1];
        rs_pref  <= base_q[win_idx][2];
      end else begin
        rs_hit   <= 1'b0;
        rs_win   <= '0;
        rs_addr  <= '0;
        rs_ctype <= '0;
        rs_pref  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lwin_xlate_chk.sv
module lwin_xlate_chk
  import lwin_pkg::*;
#(
  parameter int NWIN  = 3,
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [AW-1:0]    lk_addr,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic [WIN_W-1:0] rs_win,
  input logic [AW-1:0]    rs_addr,
  input logic [CT_W-1:0]  rs_ctype,
  input logic             rs_pref,
  input logic [NWIN-1:0]  match_vec,
  input logic [NWIN-1:0]  win_oh
);
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid); // R2
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_hit |-> (rs_addr == '0 && rs_ctype == '0 && !rs_pref && rs_win == '0)); // R9
  AST_LOW_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rs_hit || rs_addr[PAGE_W-1:2] == $past(lk_addr[PAGE_W-1:2]))); // R5
  AST_HIT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rs_hit == $past(|match_vec))); // R6
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((match_vec == '0) || ($countones(win_oh) == 1))); // R6
  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |-> (int'(rs_win) < NWIN)); // R6
endmodule

bind lwin_xlate lwin_xlate_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_win(rs_win), .rs_addr(rs_addr),
  .rs_ctype(rs_ctype), .rs_pref(rs_pref), .match_vec(match_vec), .win_oh(win_oh)
);

// File: tb/lwin_xlate_tb.sv
module lwin_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;

  typedef struct {
    logic        hit;
    logic [1:0]  win;
    logic [31:0] addr;
    logic [2:0]  ctype;
    logic        pref;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, lk_valid = 1'b0;
  logic [1:0]  cfg_win = '0;
  logic [31:0] cfg_wdata = '0, lk_addr = '0;
  logic rs_valid, rs_hit, rs_pref;
  logic [1:0]  rs_win;
  logic [31:0] rs_addr;
  logic [2:0]  rs_ctype;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  exp_t sb[$];
  logic [31:0] sh_base [NW];
  logic [15:0] sh_map  [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  lwin_xlate #(.NWIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_win(rs_win),
    .rs_addr(rs_addr), .rs_ctype(rs_ctype), .rs_pref(rs_pref)
  );

  // Reference model written from the requirement text.
  function automatic exp_t model(input logic [31:0] a, input string req);
    exp_t e;
    e = '{hit: 0, win: 0, addr: 0, ctype: 0, pref: 0, req: req};
    for (int w = 0; w < NW; w++) begin
      int lg;
      logic [63:0] lowm;
      logic [31:0] pa;
      lg = 20 + ((int'(sh_base[w][7:4]) > 12) ? 12 : int'(sh_base[w][7:4]));
      lowm = (64'd1 << lg) - 64'd1;
      if (sh_base[w][0] && ((({32'd0, a} ^ {32'd0, sh_base[w]}) & ~lowm & 64'hFFFF_FFFF) == 0)) begin
        pa = ({sh_map[w][15:4], 20'd0} & ~lowm[31:0]) | (a & lowm[31:0]);
        if (sh_map[w][3:1] == 3'b101 && !sh_map[w][0]) pa[1:0] = 2'b00;
        e.hit = 1; e.win = 2'(w); e.addr = pa;
        e.ctype = sh_map[w][3:1]; e.pref = sh_base[w][2];
        return e;
      end
    end
    return e;
  endfunction

  task automatic cyc(input logic we, input logic [1:0] win, input logic sel,
                     input logic [31:0] wd, input logic lv, input logic [31:0] la,
                     input string req);
    @(negedge clk);
    cfg_we = we; cfg_win = win; cfg_sel = sel; cfg_wdata = wd;
    lk_valid = lv; lk_addr = la;
    if (lv) sb.push_back(model(la, req));
    if (we && int'(win) < NW) begin
      if (!sel) sh_base[win] = wd;
      else      sh_map[win]  = wd[15:0];
    end
  endtask

  task automatic wr(input logic [1:0] win, input logic sel, input logic [31:0] wd);
    cyc(1, win, sel, wd, 0, 0, "");
  endtask

  task automatic look(input logic [31:0] a, input string req);
    cyc(0, 0, 0, 0, 1, a, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, "");
  endtask

  // Monitor: pops expected results as the design produces them.
  always @(negedge clk) begin
    if (rst_n && rs_valid) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R2: result with no pending lookup, actual addr=%h expected none", rs_addr);
      end else begin
        e = sb.pop_front();
        if (rs_hit !== e.hit || rs_win !== e.win || rs_addr !== e.addr ||
            rs_ctype !== e.ctype || rs_pref !== e.pref) begin
          n_bad++;
          $display("FAIL %s: actual hit=%b win=%0d addr=%h ct=%b pf=%b expected hit=%b win=%0d addr=%h ct=%b pf=%b",
                   e.req, rs_hit, rs_win, rs_addr, rs_ctype, rs_pref,
                   e.hit, e.win, e.addr, e.ctype, e.pref);
        end
      end
    end
  end

  task automatic check_reset;
    n_chk++;
    if (rs_valid !== 1'b0 || rs_hit !== 1'b0 || rs_addr !== 32'd0) begin
      n_bad++;
      $display("FAIL R1: actual valid=%b hit=%b addr=%h expected 0 0 00000000",
               rs_valid, rs_hit, rs_addr);
    end
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin sh_base[w] = '0; sh_map[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();                                  // R1
    look(32'h4000_0000, "R1");                      // all disabled -> miss
    // 256 MB memory windows and a disabled 16 MB window
    wr(0, 0, 32'h4000_0081); wr(0, 1, 32'h0000_0006);
    wr(1, 0, 32'h5000_0085); wr(1, 1, 32'h0000_1006);
    wr(2, 0, 32'h6000_0040); wr(2, 1, 32'h0000_0000);
    look(32'h4123_4567, "R5");
    look(32'h5ABC_DEF3, "R7");
    look(32'h6000_1234, "R3");                      // disabled window
    look(32'h3FFF_FFFF, "R4");
    look(32'h4FFF_FFFF, "R4");
    look(32'h6000_0000, "R9");
    wr(2, 0, 32'h6000_0041);
    look(32'h6000_1234, "R3");                      // now enabled, offset 0 -> 0
    look(32'h6100_0000, "R4");                      // just past 16 MB
    // Enlarge window 0 to 512 MB: it hides window 1
    wr(0, 0, 32'h4000_0091);
    look(32'h5000_0010, "R6");
    look(32'h5FFF_FFFF, "R6");
    // Retarget window 1 to configuration space
    wr(1, 0, 32'h6800_0041); wr(1, 1, 32'h0000_000A);
    look(32'h6800_0813, "R8");
    wr(1, 1, 32'h0000_080B);
    look(32'h6830_0813, "R8");
    wr(1, 1, 32'h0000_0006);
    look(32'h6800_0813, "R8");
    // 1 MB window, then a clamped whole-space window
    wr(2, 0, 32'h7010_0001); wr(2, 1, 32'h0000_1236);
    look(32'h7018_0000, "R4");
    look(32'h7020_0000, "R4");
    wr(2, 0, 32'h0000_00F1); wr(2, 1, 32'h0000_0006);
    look(32'hC000_0004, "R4");
    look(32'h4000_0000, "R6");
    // Write and lookup in the same cycle: old value seen
    cyc(1, 2, 0, 32'h0000_0000, 1, 32'hC000_0004, "R10");
    look(32'hC000_0004, "R10");
    wr(3, 0, 32'h0000_00F1);                        // out of range index ignored
    look(32'hC000_0004, "R10");
    idle(4);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2: actual %0d results missing expected 0", sb.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2: watchdog expired, actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule